// File: doc/BRIEF.md
# Dual-Bank Phase Accumulator Core

This block is the phase generator of a direct digital synthesizer. Each reference-clock cycle, a 28-bit modulo-2^28 accumulator adds a frequency tuning word. The output frequency is therefore `word * fclk / 2^28`. A 12-bit phase offset is then added to the top of the accumulator value. The sum is the output phase, which a downstream phase-to-amplitude stage consumes.

The core holds two tuning-word registers and four offset registers, all written through a plain write port (enable, 3-bit address, data). Two select inputs choose which tuning word drives the accumulator and which offset is applied at the output. The tuning word can be swapped without clearing the accumulator, so frequency hops are phase-continuous. Offset changes shift the phase without touching the frequency. An active-low asynchronous reset puts every core on a shared clock and reset at phase zero, so several cores start coherently.

Top module: `phacc_top`

## Requirements
- R1: While `rstN` is low, `phaseOut` is zero and all six registers are cleared. Writes presented during reset are lost. After release, the accumulator starts counting from zero.
- R2: On each rising clock edge with `rstN` high, the accumulator grows by the tuning word selected by `freqSel`, as that word stood before the edge.
- R3: Accumulation wraps modulo 2^28, with no saturation.
- R4: `freqSel` = 0 selects tuning register 0 and `freqSel` = 1 selects tuning register 1. Changing `freqSel` never resets or jumps the accumulator; only the step size changes.
- R5: A write with `wrEn` high to address 0 or 1 loads all 28 bits of `wrData` into tuning register 0 or 1 at that clock edge. The new word is first added at the following edge.
- R6: A write to address 2, 3, 4 or 5 loads `wrData[11:0]` into offset register 0, 1, 2 or 3. `phaseOut` equals the accumulator plus the selected offset shifted left by 16, modulo 2^28. The result is visible right after the loading edge.
- R7: `phaseSel` (0 to 3) picks the offset register. The choice acts on `phaseOut` combinationally, within the same cycle.
- R8: Writes to address 6 or 7, and any cycle with `wrEn` low, change no register.
- R9: The offset never alters the frequency: the low 16 bits of `phaseOut` always equal those of the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 3 | Register address: 0-1 tuning, 2-5 offset |
| wrData | input | 28 | Write data (offsets use bits 11:0) |
| freqSel | input | 1 | Active tuning register |
| phaseSel | input | 2 | Active offset register |
| phaseOut | output | 28 | Accumulator plus selected offset |

## Verification
A corrupted accumulator shows on `phaseOut` at the very next edge, because every cycle's value is predicted exactly from the previous one. It persists from then on, because the accumulator never forgets an error. A wrong tuning register shows as a wrong step one edge after it is selected. A wrong offset register shows in the same cycle that `phaseSel` points at it. A mis-decoded address is caught once the register it wrongly altered is selected.

// File: rtl/phacc_pkg.sv
package phacc_pkg;
  localparam int ACC_W     = 28;
  localparam int OFS_W     = 12;
  localparam int NUM_FREQ  = 2;
  localparam int NUM_PHASE = 4;
  localparam int ADDR_W    = 3;
  localparam int FSEL_W    = $clog2(NUM_FREQ);
  localparam int PSEL_W    = $clog2(NUM_PHASE);
  localparam int PHASE_BASE = NUM_FREQ;

  typedef struct packed {
    logic [NUM_PHASE-1:0] phaseWr;
    logic [NUM_FREQ-1:0]  freqWr;
  } wrStrobe_t;
endpackage

// File: rtl/phacc_ctrl.sv
module phacc_ctrl
  import phacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output wrStrobe_t         strobe
);
  logic [NUM_FREQ-1:0]  freqHit;
  logic [NUM_PHASE-1:0] phaseHit;

  always_comb begin
    for (int i = 0; i < NUM_FREQ; i++)
      freqHit[i] = wrEn && (wrAddr == ADDR_W'(i));
    for (int j = 0; j < NUM_PHASE; j++)
      phaseHit[j] = wrEn && (wrAddr == ADDR_W'(PHASE_BASE + j));
  end

  assign strobe.freqWr  = freqHit;
  assign strobe.phaseWr = phaseHit;

  // R8: at most one register is written per cycle
  a_r8_onehot_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R8: unused addresses write nothing
  a_r8_unused_addr: assert property (@(posedge clk) disable iff (!rstN)
    (int'(wrAddr) >= NUM_FREQ + NUM_PHASE) |-> (strobe == '0));
endmodule

// File: rtl/phacc_datapath.sv
module phacc_datapath
  import phacc_pkg::*;
#(
  parameter int AccW = ACC_W,
  parameter int OfsW = OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [AccW-1:0]   wrData,
  input  logic [FSEL_W-1:0] freqSel,
  input  logic [PSEL_W-1:0] phaseSel,
  output logic [AccW-1:0]   phaseOut
);
  localparam int SHIFT = AccW - OfsW;

  logic [AccW-1:0] freqReg [NUM_FREQ];
  logic [OfsW-1:0] ofsReg  [NUM_PHASE];
  logic [AccW-1:0] accQ;
  logic [AccW-1:0] stepWord;
  logic [AccW-1:0] ofsAligned;

  for (genvar g = 0; g < NUM_FREQ; g++) begin : gFreq
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 freqReg[g] <= '0;
      else if (strobe.freqWr[g]) freqReg[g] <= wrData;
    end
    // R8: a tuning register only moves when strobed
    a_r8_freq_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.freqWr[g] |=> $stable(freqReg[g]));
  end

  for (genvar h = 0; h < NUM_PHASE; h++) begin : gOfs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  ofsReg[h] <= '0;
      else if (strobe.phaseWr[h]) ofsReg[h] <= wrData[OfsW-1:0];
    end
    // R8: an offset register only moves when strobed
    a_r8_ofs_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.phaseWr[h] |=> $stable(ofsReg[h]));
  end

  assign stepWord   = freqReg[freqSel];
  assign ofsAligned = {ofsReg[phaseSel], {SHIFT{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accQ <= '0;
    else       accQ <= accQ + stepWord;
  end

  assign phaseOut = accQ + ofsAligned;

  // R1: reset holds phase at zero
  a_r1_reset_zero: assert property (@(posedge clk)
    !rstN |-> (accQ == '0 && phaseOut == '0));

  // R2: accumulator advances by the previously selected word
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (accQ == AccW'($past(accQ) + $past(stepWord))));

  // R9: offset leaves the low phase bits untouched
  a_r9_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    phaseOut[SHIFT-1:0] == accQ[SHIFT-1:0]);
endmodule

// File: rtl/phacc_top.sv
module phacc_top
  import phacc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ACC_W-1:0]  wrData,
  input  logic [FSEL_W-1:0] freqSel,
  input  logic [PSEL_W-1:0] phaseSel,
  output logic [ACC_W-1:0]  phaseOut
);
  wrStrobe_t strobe;

  phacc_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  phacc_datapath #(.AccW(ACC_W), .OfsW(OFS_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (wrData),
    .freqSel  (freqSel),
    .phaseSel (phaseSel),
    .phaseOut (phaseOut)
  );
endmodule

// File: tb/phacc_top_test.sv
`timescale 1ns/1ps
module phacc_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [27:0] wrData = '0;
  logic        freqSel = 1'b0;
  logic [1:0]  phaseSel = '0;
  logic [27:0] phaseOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [27:0] exp; string tag; } item_t;
  item_t q[$];

  // reference model state (derived from the requirements)
  logic [27:0] mAcc = '0;
  logic [27:0] mFreq [2] = '{default: '0};
  logic [11:0] mOfs  [4] = '{default: '0};
  logic        cWe = 0, cRn = 0, cFs = 0;
  logic [2:0]  cA = '0;
  logic [27:0] cD = '0;

  phacc_top uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .freqSel(freqSel), .phaseSel(phaseSel), .phaseOut(phaseOut)
  );

  always #2 clk = ~clk; // 250 MHz

  task automatic step(input logic we, input logic [2:0] a, input logic [27:0] d,
                      input logic fs, input logic [1:0] ps, input logic rn,
                      input string tag);
    @(posedge clk);
    if (cRn) begin
      mAcc = mAcc + mFreq[cFs];
      if (cWe) begin
        if (cA < 3'd2) mFreq[cA[0]] = cD;
        else if (cA < 3'd6) mOfs[int'(cA) - 2] = cD[11:0];
      end
    end
    #1;
    wrEn = we; wrAddr = a; wrData = d; freqSel = fs; phaseSel = ps; rstN = rn;
    cWe = we; cA = a; cD = d; cFs = fs; cRn = rn;
    if (!rn) begin
      mAcc = '0;
      for (int i = 0; i < 2; i++) mFreq[i] = '0;
      for (int i = 0; i < 4; i++) mOfs[i] = '0;
    end
    q.push_back('{exp: rn ? mAcc + {mOfs[ps], 16'h0} : 28'h0, tag: tag});
  endtask

  task automatic idle(input logic fs, input logic [1:0] ps, input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 3'd0, 28'h0, fs, ps, 1'b1, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (phaseOut !== it.exp) begin
        errors++;
        $display("FAIL %s: phaseOut=%h expected=%h", it.tag, phaseOut, it.exp);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset, with a write attempted while in reset
    step(1'b1, 3'd0, 28'h0ABCDEF, 1'b0, 2'd0, 1'b0, "R1 reset");
    step(1'b0, 3'd0, 28'h0, 1'b0, 2'd0, 1'b0, "R1 reset");
    idle(1'b0, 2'd0, 3, "R1 release, registers clear");
    // R5, R2: load tuning word 0
    step(1'b1, 3'd0, 28'h0123456, 1'b0, 2'd0, 1'b1, "R5 freq0 write");
    idle(1'b0, 2'd0, 4, "R2 accumulate freq0");
    // R5: load tuning word 1 while using 0
    step(1'b1, 3'd1, 28'h0F00001, 1'b0, 2'd0, 1'b1, "R5 freq1 write");
    idle(1'b0, 2'd0, 2, "R2 freq0 still active");
    // R4: switch, phase-continuous
    idle(1'b1, 2'd0, 4, "R4 switch to freq1");
    idle(1'b0, 2'd0, 2, "R4 switch back to freq0");
    // R6, R7: offset registers
    step(1'b1, 3'd2, 28'hFFFF123, 1'b0, 2'd0, 1'b1, "R6 ofs0 write");
    step(1'b1, 3'd3, 28'h0000800, 1'b0, 2'd0, 1'b1, "R6 ofs1 write");
    step(1'b1, 3'd4, 28'h0000FFF, 1'b0, 2'd1, 1'b1, "R7 ofs2 write, select 1");
    step(1'b1, 3'd5, 28'h0000001, 1'b0, 2'd2, 1'b1, "R7 ofs3 write, select 2");
    idle(1'b0, 2'd3, 2, "R7 select 3");
    idle(1'b1, 2'd0, 3, "R9 offset does not change frequency");
    // R8: unused addresses and wrEn low
    step(1'b1, 3'd6, 28'h7777777, 1'b0, 2'd0, 1'b1, "R8 addr6 ignored");
    step(1'b1, 3'd7, 28'h5555555, 1'b1, 2'd1, 1'b1, "R8 addr7 ignored");
    idle(1'b0, 2'd2, 2, "R8 registers unchanged");
    idle(1'b1, 2'd3, 2, "R8 registers unchanged");
    // R3: wrap with large words
    step(1'b1, 3'd0, 28'hFFFFFFF, 1'b0, 2'd0, 1'b1, "R3 large word write");
    idle(1'b0, 2'd0, 4, "R3 wrap modulo 2^28");
    step(1'b1, 3'd1, 28'h8000000, 1'b1, 2'd1, 1'b1, "R3 half-turn word");
    idle(1'b1, 2'd1, 3, "R3 wrap half-turn");
    // R1: mid-run reset and restart
    step(1'b0, 3'd0, 28'h0, 1'b0, 2'd1, 1'b0, "R1 mid-run reset");
    idle(1'b0, 2'd1, 2, "R1 restart from zero");
    step(1'b1, 3'd0, 28'h0000010, 1'b0, 2'd0, 1'b1, "R5 reload after reset");
    idle(1'b0, 2'd0, 3, "R2 count after reset");
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule